// File: doc/BRIEF.md
# PCI Initiator Bus-Phase Sequencer

This block is the initiator half of a 32-bit multiplexed PCI bus. A local client hands it one request at a time: a command code, a 64-bit address, a read/write flag, a burst length of one to eight data phases, and for writes the data words with their byte enables. Once the bus is granted and quiet, the block runs the address phase, or phases, and then the data phases. It pairs its IRDY# with the target's TRDY# and returns each read word on a local strobe. At the end it drives the bus controls high for one clock and then releases them.

When the upper half of the address is zero, a single address phase is used. Otherwise a dual-address sequence is issued. Every bus signal the block drives has its own output enable, so the surrounding logic or a bench can see three things: the one-clock drive-high at the end of a transaction, the hand-over to the pull-ups after it, and the parking of AD and C/BE# while the bus sits idle under grant.

Top module: `pci_init_seq`

## Requirements
- R1: A request is taken on a clock where `start_i` is high and `busy_o` is low. Requests offered while `busy_o` is high are dropped. The first address phase begins only after a clock on which the request is held, `gnt_ni` is low, and `frame_ni` and `irdy_ni` are both high. FRAME# is driven low throughout the address phases.
- R2: When `addr_i[63:32]` is zero, exactly one address phase is issued, with AD = `addr_i[31:0]` and C/BE# = `cmd_i`.
- R3: When `addr_i[63:32]` is nonzero, two address phases are issued. The first carries AD = `addr_i[31:0]` with C/BE# = 4'b1101. The second carries AD = `addr_i[63:32]` with C/BE# = `cmd_i`.
- R4: IRDY# is driven high during address phases and driven low from the clock after the last address phase. It stays low through every data phase. A data phase completes only on a clock where `trdy_ni` is low.
- R5: The burst has `len_i`+1 data phases. FRAME# is low in every data phase except the final one, where it is high.
- R6: With `wr_i`=1, data phase k drives AD = `wdata_i[32k+31:32k]` and C/BE# = `be_i[4k+3:4k]`, with both enables high.
- R7: With `wr_i`=0, the AD enable is low in data phases while C/BE# still carries `be_i[4k+3:4k]`. For each clock where phase k completes, `rvalid_o` is high on the next clock and `rdata_o` holds the `ad_i` value sampled on that edge.
- R8: After the final data phase completes, there is one clock in which FRAME# and IRDY# are driven high, the AD and C/BE# enables are low, and `done_o` is high. On the next clock FRAME# and IRDY# are undriven and `busy_o` is low. After reset the block is idle, with all enables low.
- R9: While no transaction is running, `frame_ni` and `irdy_ni` are high and `gnt_ni` is low, the block parks the bus: the AD and C/BE# enables are high and both carry zero. With `gnt_ni` high, neither is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe |
| cmd_i | input | 4 | Bus command code |
| addr_i | input | 64 | Transaction address |
| wr_i | input | 1 | 1 = write, 0 = read |
| len_i | input | 3 | Data phases minus one |
| wdata_i | input | 256 | Write words, word k at bits 32k+31:32k |
| be_i | input | 32 | Active-low byte enables, phase k at bits 4k+3:4k |
| busy_o | output | 1 | Request held or transaction running |
| done_o | output | 1 | Release clock of a transaction |
| rvalid_o | output | 1 | Read word strobe |
| rdata_o | output | 32 | Read word |
| gnt_ni | input | 1 | Bus grant, active low |
| trdy_ni | input | 1 | Target ready, active low |
| frame_ni | input | 1 | Sampled FRAME# bus level |
| irdy_ni | input | 1 | Sampled IRDY# bus level |
| ad_i | input | 32 | Sampled AD bus |
| ad_o | output | 32 | AD drive value |
| ad_oe_o | output | 1 | AD drive enable |
| cbe_o | output | 4 | C/BE# drive value |
| cbe_oe_o | output | 1 | C/BE# drive enable |
| frame_o | output | 1 | FRAME# drive value |
| frame_oe_o | output | 1 | FRAME# drive enable |
| irdy_o | output | 1 | IRDY# drive value |
| irdy_oe_o | output | 1 | IRDY# drive enable |

## Verification
Parking and launch share a clock. On the idle clock where a held request is launched, the grant is already low, so AD and C/BE# are parked at zero. On the next clock they must switch straight to the first address phase with no undriven gap. The bench keeps `gnt_ni` low across the request and the launch so that these two coincide. It checks, every clock, that the parked zeros come first and the address follows right after.

A second overlap comes when the final read phase completes. The word capture and the FRAME#/IRDY# release fall on the same edge. The bench judges this clock by the read strobe together with the drive-high pattern and `done_o`.

// File: rtl/pci_seq_pkg.sv
package pci_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADR_LO, ST_ADR_HI, ST_DATA, ST_REL
  } seq_state_e;

  localparam logic [3:0] CMD_DUAL_ADDR = 4'b1101;
endpackage

// File: rtl/pci_seq_req.sv
module pci_seq_req #(
  parameter int MAX_BEATS = 8,
  parameter int DW        = 32,
  localparam int CW       = DW / 8,
  localparam int BW       = $clog2(MAX_BEATS),
  localparam int AW       = 2 * DW
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      take_i,
  input  logic [3:0]                cmd_i,
  input  logic [AW-1:0]             addr_i,
  input  logic                      wr_i,
  input  logic [BW-1:0]             len_i,
  input  logic [MAX_BEATS*DW-1:0]   wdata_i,
  input  logic [MAX_BEATS*CW-1:0]   be_i,
  input  logic [BW-1:0]             beat_i,
  output logic [3:0]                cmd_o,
  output logic [AW-1:0]             addr_o,
  output logic                      wr_o,
  output logic                      dual_o,
  output logic [BW-1:0]             len_o,
  output logic [DW-1:0]             wd_o,
  output logic [CW-1:0]             be_o
);
  logic [MAX_BEATS*DW-1:0] wdata_q;
  logic [MAX_BEATS*CW-1:0] be_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_o   <= '0;
      addr_o  <= '0;
      wr_o    <= 1'b0;
      len_o   <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (take_i) begin
      cmd_o   <= cmd_i;
      addr_o  <= addr_i;
      wr_o    <= wr_i;
      len_o   <= len_i;
      wdata_q <= wdata_i;
      be_q    <= be_i;
    end
  end

  assign dual_o = |addr_o[AW-1:DW];
  assign wd_o   = wdata_q[beat_i*DW +: DW];
  assign be_o   = be_q[beat_i*CW +: CW];
endmodule

// File: rtl/pci_seq_ctrl.sv
module pci_seq_ctrl
  import pci_seq_pkg::*;
#(
  parameter int MAX_BEATS = 8,
  localparam int BW       = $clog2(MAX_BEATS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          gnt_ni,
  input  logic          bus_idle_i,
  input  logic          dual_i,
  input  logic          trdy_ni,
  input  logic [BW-1:0] len_i,
  output seq_state_e    state_o,
  output logic [BW-1:0] beat_o,
  output logic          take_o,
  output logic          pend_o,
  output logic          last_o,
  output logic          complete_o
);
  seq_state_e    state_q;
  logic [BW-1:0] beat_q;
  logic          pend_q;

  assign take_o     = start_i && state_q == ST_IDLE && !pend_q;
  assign last_o     = beat_q == len_i;
  assign complete_o = state_q == ST_DATA && !trdy_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
      pend_q  <= 1'b0;
    end else begin
      if (take_o) pend_q <= 1'b1;
      unique case (state_q)
        ST_IDLE: if (pend_q && !gnt_ni && bus_idle_i) begin
          state_q <= ST_ADR_LO;
          pend_q  <= 1'b0;
        end
        ST_ADR_LO: begin
          state_q <= dual_i ? ST_ADR_HI : ST_DATA;
          beat_q  <= '0;
        end
        ST_ADR_HI: state_q <= ST_DATA;
        ST_DATA: if (complete_o) begin
          if (last_o) state_q <= ST_REL;
          else        beat_q  <= beat_q + 1'b1;
        end
        ST_REL: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign beat_o  = beat_q;
  assign pend_o  = pend_q;
endmodule

// File: rtl/pci_init_seq.sv
module pci_init_seq
  import pci_seq_pkg::*;
#(
  parameter int MAX_BEATS = 8,
  parameter int DW        = 32,
  localparam int CW       = DW / 8,
  localparam int BW       = $clog2(MAX_BEATS),
  localparam int AW       = 2 * DW
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [3:0]              cmd_i,
  input  logic [AW-1:0]           addr_i,
  input  logic                    wr_i,
  input  logic [BW-1:0]           len_i,
  input  logic [MAX_BEATS*DW-1:0] wdata_i,
  input  logic [MAX_BEATS*CW-1:0] be_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    rvalid_o,
  output logic [DW-1:0]           rdata_o,
  input  logic                    gnt_ni,
  input  logic                    trdy_ni,
  input  logic                    frame_ni,
  input  logic                    irdy_ni,
  input  logic [DW-1:0]           ad_i,
  output logic [DW-1:0]           ad_o,
  output logic                    ad_oe_o,
  output logic [CW-1:0]           cbe_o,
  output logic                    cbe_oe_o,
  output logic                    frame_o,
  output logic                    frame_oe_o,
  output logic                    irdy_o,
  output logic                    irdy_oe_o
);
  seq_state_e    state;
  logic [BW-1:0] beat, len;
  logic          take, pend, last, complete, dual, wr;
  logic [3:0]    cmd;
  logic [AW-1:0] addr;
  logic [DW-1:0] wd;
  logic [CW-1:0] be;
  logic          bus_idle, park;

  assign bus_idle = frame_ni && irdy_ni;
  assign park     = state == ST_IDLE && !gnt_ni && bus_idle;

  pci_seq_ctrl #(.MAX_BEATS(MAX_BEATS)) u_ctrl (
    .clk_i, .rst_ni, .start_i, .gnt_ni,
    .bus_idle_i(bus_idle), .dual_i(dual), .trdy_ni, .len_i(len),
    .state_o(state), .beat_o(beat), .take_o(take), .pend_o(pend),
    .last_o(last), .complete_o(complete)
  );

  pci_seq_req #(.MAX_BEATS(MAX_BEATS), .DW(DW)) u_req (
    .clk_i, .rst_ni, .take_i(take), .cmd_i, .addr_i, .wr_i, .len_i,
    .wdata_i, .be_i, .beat_i(beat),
    .cmd_o(cmd), .addr_o(addr), .wr_o(wr), .dual_o(dual), .len_o(len),
    .wd_o(wd), .be_o(be)
  );

  // read capture is registered: strobe follows the completing edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      rvalid_o <= complete && !wr;
      if (complete && !wr) rdata_o <= ad_i;
    end
  end

  assign busy_o = pend || state != ST_IDLE;
  assign done_o = state == ST_REL;

  always_comb begin
    ad_o       = '0;
    ad_oe_o    = 1'b0;
    cbe_o      = '0;
    cbe_oe_o   = 1'b0;
    frame_o    = 1'b1;
    frame_oe_o = 1'b0;
    irdy_o     = 1'b1;
    irdy_oe_o  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        ad_oe_o  = park;
        cbe_oe_o = park;
      end
      ST_ADR_LO, ST_ADR_HI: begin
        frame_o    = 1'b0;
        frame_oe_o = 1'b1;
        irdy_oe_o  = 1'b1;
        ad_oe_o    = 1'b1;
        cbe_oe_o   = 1'b1;
        if (state == ST_ADR_LO) begin
          ad_o  = addr[DW-1:0];
          cbe_o = dual ? CMD_DUAL_ADDR : cmd;
        end else begin
          ad_o  = addr[AW-1:DW];
          cbe_o = cmd;
        end
      end
      ST_DATA: begin
        frame_o    = last;
        frame_oe_o = 1'b1;
        irdy_o     = 1'b0;
        irdy_oe_o  = 1'b1;
        ad_oe_o    = wr;
        ad_o       = wr ? wd : '0;
        cbe_o      = be;
        cbe_oe_o   = 1'b1;
      end
      ST_REL: begin
        frame_oe_o = 1'b1;
        irdy_oe_o  = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/pci_init_seq_chk.sv
module pci_init_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic gnt_ni,
  input logic trdy_ni,
  input logic frame_ni,
  input logic irdy_ni,
  input logic frame_o,
  input logic frame_oe_o,
  input logic irdy_o,
  input logic irdy_oe_o,
  input logic ad_oe_o,
  input logic cbe_oe_o,
  input logic done_o,
  input logic busy_o
);
  a_r1_launch_on_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(frame_oe_o) |-> (!$past(gnt_ni) && !frame_o));

  a_r4_irdy_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irdy_oe_o && !irdy_o && trdy_ni) |=> (irdy_oe_o && !irdy_o));

  a_r5_final_phase_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irdy_oe_o && !irdy_o && frame_oe_o && frame_o && !trdy_ni) |=> done_o);

  a_r8_drive_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (frame_oe_o && frame_o && irdy_oe_o && irdy_o && !ad_oe_o && !cbe_oe_o));

  a_r8_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!frame_oe_o && !irdy_oe_o && !busy_o));

  a_r9_park: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!frame_oe_o && !gnt_ni && frame_ni && irdy_ni) |-> (ad_oe_o && cbe_oe_o));
endmodule

bind pci_init_seq pci_init_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .gnt_ni(gnt_ni), .trdy_ni(trdy_ni),
  .frame_ni(frame_ni), .irdy_ni(irdy_ni), .frame_o(frame_o),
  .frame_oe_o(frame_oe_o), .irdy_o(irdy_o), .irdy_oe_o(irdy_oe_o),
  .ad_oe_o(ad_oe_o), .cbe_oe_o(cbe_oe_o), .done_o(done_o), .busy_o(busy_o)
);

// File: tb/pci_init_seq_test.sv
module pci_init_seq_test;
  localparam int MB = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, wr_i = 1'b0;
  logic [3:0] cmd_i = '0;
  logic [63:0] addr_i = '0;
  logic [2:0] len_i = '0;
  logic [MB*32-1:0] wdata_i = '0;
  logic [MB*4-1:0] be_i = '0;
  logic gnt_ni = 1'b1, trdy_ni = 1'b1;
  logic [31:0] ad_in = '0;
  logic busy_o, done_o, rvalid_o, ad_oe_o, cbe_oe_o, frame_o, frame_oe_o, irdy_o, irdy_oe_o;
  logic [31:0] rdata_o, ad_o;
  logic [3:0] cbe_o;
  logic frame_bus, irdy_bus;

  assign frame_bus = frame_oe_o ? frame_o : 1'b1;
  assign irdy_bus  = irdy_oe_o ? irdy_o : 1'b1;

  always #5 clk_i = ~clk_i;

  pci_init_seq uut (
    .clk_i, .rst_ni, .start_i, .cmd_i, .addr_i, .wr_i, .len_i, .wdata_i, .be_i,
    .busy_o, .done_o, .rvalid_o, .rdata_o, .gnt_ni, .trdy_ni,
    .frame_ni(frame_bus), .irdy_ni(irdy_bus), .ad_i(ad_in),
    .ad_o, .ad_oe_o, .cbe_o, .cbe_oe_o, .frame_o, .frame_oe_o, .irdy_o, .irdy_oe_o
  );

  int n_chk = 0, n_err = 0, cyc = 0, trdy_mode = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  // behavioural reference
  int m_step, m_k;  // 0 idle,1 low addr,2 high addr,3 data,4 release
  bit m_pend, m_rv, m_wr, m_dual;
  logic [31:0] m_rd;
  logic [3:0] m_cmd;
  logic [63:0] m_addr;
  int m_len;
  logic [MB*32-1:0] m_wd;
  logic [MB*4-1:0] m_be;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_step = 0; m_k = 0; m_pend = 0; m_rv = 0; m_rd = '0;
    end else begin
      bit acc;
      acc = start_i && !m_pend && m_step == 0;
      m_rv = 0;
      case (m_step)
        0: if (m_pend && !gnt_ni) begin m_step = 1; m_pend = 0; end
        1: begin m_step = m_dual ? 2 : 3; m_k = 0; end
        2: m_step = 3;
        3: if (!trdy_ni) begin
             if (!m_wr) begin m_rv = 1; m_rd = ad_in; end
             if (m_k == m_len) m_step = 4; else m_k++;
           end
        default: m_step = 0;
      endcase
      if (acc) begin
        m_pend = 1; m_cmd = cmd_i; m_addr = addr_i; m_wr = wr_i;
        m_len = int'(len_i); m_wd = wdata_i; m_be = be_i; m_dual = addr_i[63:32] != 0;
      end
    end
  end

  // compare every cycle away from the active edge
  always @(negedge clk_i) begin
    bit park, e_ad_oe, e_cbe_oe;
    logic [31:0] e_ad;
    logic [3:0] e_cbe;
    string tg;
    park = m_step == 0 && !gnt_ni;
    e_ad_oe  = park || m_step == 1 || m_step == 2 || (m_step == 3 && m_wr);
    e_cbe_oe = park || (m_step >= 1 && m_step <= 3);
    e_ad = '0; e_cbe = '0;
    tg = park ? "R9" : (m_step == 3 ? (m_wr ? "R6" : "R7") : (m_dual ? "R3" : "R2"));
    case (m_step)
      1: begin e_ad = m_addr[31:0]; e_cbe = m_dual ? 4'b1101 : m_cmd; end
      2: begin e_ad = m_addr[63:32]; e_cbe = m_cmd; end
      3: begin e_ad = m_wd[m_k*32 +: 32]; e_cbe = m_be[m_k*4 +: 4]; end
      default: ;
    endcase
    chk(busy_o === (m_pend || m_step != 0), "R1", "busy", busy_o, m_pend || m_step != 0);
    chk(done_o === (m_step == 4), "R8", "done", done_o, m_step == 4);
    chk(ad_oe_o === e_ad_oe, tg, "ad_oe", ad_oe_o, e_ad_oe);
    chk(cbe_oe_o === e_cbe_oe, tg, "cbe_oe", cbe_oe_o, e_cbe_oe);
    if (e_ad_oe)  chk(ad_o === e_ad, tg, "ad", ad_o, e_ad);
    if (e_cbe_oe) chk(cbe_o === e_cbe, tg, "cbe", cbe_o, e_cbe);
    chk(frame_oe_o === (m_step != 0), "R8", "frame_oe", frame_oe_o, m_step != 0);
    chk(irdy_oe_o === (m_step != 0), "R8", "irdy_oe", irdy_oe_o, m_step != 0);
    if (m_step == 1 || m_step == 2) begin
      chk(frame_o === 1'b0, "R1", "frame addr", frame_o, 0);
      chk(irdy_o === 1'b1, "R4", "irdy addr", irdy_o, 1);
    end
    if (m_step == 3) begin
      chk(frame_o === (m_k == m_len), "R5", "frame data", frame_o, m_k == m_len);
      chk(irdy_o === 1'b0, "R4", "irdy data", irdy_o, 0);
    end
    if (m_step == 4) begin
      chk(frame_o === 1'b1, "R8", "frame rel", frame_o, 1);
      chk(irdy_o === 1'b1, "R8", "irdy rel", irdy_o, 1);
    end
    chk(rvalid_o === m_rv, "R7", "rvalid", rvalid_o, m_rv);
    if (m_rv) chk(rdata_o === m_rd, "R7", "rdata", rdata_o, m_rd);
  end

  // target side: ready pattern and read data
  always @(negedge clk_i) begin
    #1;
    cyc++;
    ad_in <= 32'hA500_0000 + 32'(cyc * 7);
    case (trdy_mode)
      0: trdy_ni <= 1'b0;
      1: trdy_ni <= (cyc % 3) != 0;
      default: trdy_ni <= cyc[0];
    endcase
    if (cyc > 20000) begin
      n_err++; n_chk++;
      $display("FAIL R1 watchdog: actual=hang expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic txn(input logic [3:0] c, input logic [63:0] a, input bit w,
                     input int l, input int mode);
    @(negedge clk_i); #2;
    trdy_mode = mode;
    cmd_i = c; addr_i = a; wr_i = w; len_i = 3'(l);
    for (int k = 0; k < MB; k++) begin
      wdata_i[k*32 +: 32] = a[31:0] ^ (32'h1111_0000 * (k + 1)) ^ 32'(k);
      be_i[k*4 +: 4] = 4'(k ^ l);
    end
    start_i = 1'b1;
    @(negedge clk_i); #2;
    start_i = 1'b0;
    cmd_i = 4'hF; addr_i = 64'hDEAD;
    @(negedge clk_i); #2;
    // R1: offer ignored while busy
    start_i = 1'b1;
    @(negedge clk_i); #2;
    start_i = 1'b0;
    while (busy_o) begin @(negedge clk_i); #2; end
    @(negedge clk_i); #2;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // reset state, R8
    chk(busy_o === 1'b0 && frame_oe_o === 1'b0 && ad_oe_o === 1'b0, "R8", "reset idle",
        {busy_o, frame_oe_o, ad_oe_o}, 0);
    #2 rst_ni = 1'b1;
    @(negedge clk_i); #2;
    gnt_ni = 1'b0;          // R9 parked idle
    repeat (3) @(negedge clk_i);
    #2;
    txn(4'h6, 64'h0000_0000_1000_0040, 1'b0, 3, 1);   // R2, R7
    txn(4'h7, 64'h0000_0002_2000_0080, 1'b1, 7, 2);   // R3, R6
    // request held while grant high, R1 and R9
    @(negedge clk_i); #2;
    gnt_ni = 1'b1;
    cmd_i = 4'h7; addr_i = 64'h3000_0000; wr_i = 1'b1; len_i = 3'd0; start_i = 1'b1;
    @(negedge clk_i); #2;
    start_i = 1'b0;
    repeat (4) @(negedge clk_i);
    #2 gnt_ni = 1'b0;
    while (busy_o) begin @(negedge clk_i); #2; end
    txn(4'h6, 64'h0000_0001_4000_0000, 1'b0, 1, 0);   // R3, R7
    txn(4'h7, 64'h5000_0010, 1'b1, 0, 0);             // R5 single phase
    txn(4'h6, 64'h6000_0020, 1'b0, 7, 2);             // R4 wait states
    gnt_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule